// File: doc/BRIEF.md
# Dual-Parallel Quad-SPI Byte Striper

This block sits between a byte-stream host and a pair of quad-SPI flash devices wired side by side. Both devices share one serial clock and one active-low chip select, while each owns a private 4-bit data bus: a lower bus and an upper bus, eight data lines in all. One pulse on `start` opens a chip-select frame. The frame holds an instruction phase of `ilen_in` bytes followed by a data phase of `dlen_in` bytes, and it is configured by a bus-select field, a stripe flag and a read flag that are latched at the start.

The instruction phase is always copied to every selected bus. In the data phase with striping on and both buses selected, the bytes at even positions of the phase travel on the lower bus and the bytes at odd positions travel on the upper bus. Each bus therefore carries half the bytes, and the pair behaves as one device of twice the capacity. The split is made per byte, so no bit-level padding is needed. The host gives each flash half the logical byte address. On reads, the two nibble streams are merged back into one ordered byte stream. With striping off, each data byte goes to every selected bus at the same moment.

Each byte moves as two nibbles, most significant first, one per serial clock period. A serial clock period is two system clocks. A byte slot is four system clocks, and a striped slot carries one byte on each bus.

Top module: `dpq_striper`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `io_lo_oe`, `io_hi_oe`, `busy`, `rx_valid` and `tx_take` are all 0.
- R2: `cs_n` falls at least two clocks (one serial period) before the first `sck` rise and rises at least two clocks after the last `sck` high. `busy` lasts 8 + 4*S clocks, where S = `ilen_in` + (striped ? ceil(`dlen_in`/2) : `dlen_in`).
- R3: Instruction bytes are sent on every selected bus whatever the stripe flag.
- R4: Striping applies when `stripe_in`=1 and `sel_in`=2'b11. Data byte 2k goes on the lower bus and byte 2k+1 on the upper bus, in the same slot.
- R5: In a striped write of odd length, the last byte goes on the lower bus and `io_hi_oe` stays 0 in that slot.
- R6: In a non-striped write, each data byte goes on every selected bus, and the host stream is consumed in order through `tx_take`.
- R7: `sel_in` bit 0 enables the lower bus and bit 1 enables the upper bus. An unselected bus keeps its output enable at 0 for the whole frame. With a single bus selected, the stripe flag has no effect.
- R8: Within a bus, each byte leaves as bits [7:4] and then bits [3:0]. The nibble is launched while `sck` is 0 and is held across the `sck` rise.
- R9: In a striped read, `rx_data` presents the lower-bus byte and then the upper-bus byte of each slot, in two consecutive valid cycles. An odd final slot yields only the lower byte.
- R10: In a non-striped read, each byte is taken from the upper bus when `sel_in`=2'b10, and from the lower bus otherwise.
- R11: `start` has no effect while `busy` is 1.
- R12: During the data phase of a read, both output enables are 0.
- R13: While `cs_n` is 1, `sck` is 0 and neither bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a frame when idle |
| sel_in | input | 2 | Bus enables: bit 0 lower, bit 1 upper |
| stripe_in | input | 1 | Split data bytes across the buses |
| read_in | input | 1 | Data phase is a read |
| ilen_in | input | ILEN_W | Instruction byte count |
| dlen_in | input | DLEN_W | Data byte count |
| tx_data | input | 2*IO_W | Next host byte, taken when tx_take is 1 |
| tx_take | output | 1 | tx_data is consumed at this clock edge |
| rx_data | output | 2*IO_W | Merged read byte |
| rx_valid | output | 1 | rx_data holds a byte |
| busy | output | 1 | Frame in progress |
| cs_n | output | 1 | Shared chip select, active low |
| sck | output | 1 | Shared serial clock |
| io_lo_o | output | IO_W | Lower bus output nibble |
| io_lo_oe | output | 1 | Lower bus output enable |
| io_lo_i | input | IO_W | Lower bus input nibble |
| io_hi_o | output | IO_W | Upper bus output nibble |
| io_hi_oe | output | 1 | Upper bus output enable |
| io_hi_i | input | IO_W | Upper bus input nibble |

## Verification
`cs_n` and `busy` change on the clock edge that samples `start`. The first `sck` rise comes five clocks later, and each slot then spans four clocks, so every sent nibble is recorded while `sck` is high at the falling clock edge. The read model presents a nibble on the falling clock edge of the `sck`-high cycle, and the block captures it at the following rising edge. The lower byte of a read slot is valid in the clock after the slot's last capture, and its upper partner is valid one clock later. The bench samples `rx_valid` on every falling edge, so it observes both cycles of each byte pair. Frame length is checked by counting `busy` clocks against 8 + 4*S.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} dpq_state_e;

   typedef struct packed {
      logic [1:0] sel;
      logic       stripe;
      logic       rd;
   } dpq_cfg_t;
endpackage

// File: rtl/dpq_lane.sv
module dpq_lane #(
   parameter int IO_W = 4,
   localparam int BYTE_W = 2 * IO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              low_half,
   input  logic              cap_high,
   input  logic [IO_W-1:0]   io_i,
   output logic [IO_W-1:0]   io_o,
   output logic [BYTE_W-1:0] rx_byte
);
   logic [BYTE_W-1:0] tx_q;
   logic [IO_W-1:0]   hi_nib_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         hi_nib_q <= '0;
      end else begin
         if (load)     tx_q     <= load_byte;
         if (cap_high) hi_nib_q <= io_i;
      end
   end

   assign io_o    = low_half ? tx_q[IO_W-1:0] : tx_q[BYTE_W-1:IO_W];
   assign rx_byte = {hi_nib_q, io_i};
endmodule

// File: rtl/dpq_sched.sv
module dpq_sched
   import dpq_pkg::*;
#(
   parameter int ILEN_W = 3,
   parameter int DLEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  dpq_cfg_t          cfg_in,
   input  logic [ILEN_W-1:0] ilen_in,
   input  logic [DLEN_W-1:0] dlen_in,
   output dpq_state_e        state,
   output logic [1:0]        cnt,
   output dpq_cfg_t          cfg,
   output logic              slot_rx,
   output logic              slot_hi,
   output logic              slot_split,
   output logic              slot_end,
   output logic              load,
   output logic              nxt_split,
   output logic              take_stage,
   output logic              take_direct
);
   logic [ILEN_W-1:0] rem_i;
   logic [DLEN_W-1:0] rem_d;
   logic active, striped, nxt_ins, nxt_dat, nxt_pair, boundary;

   always_comb begin
      active      = (state == ST_SETUP) || (state == ST_SHIFT);
      striped     = cfg.stripe && (cfg.sel == 2'b11);
      nxt_ins     = (rem_i != '0);
      nxt_dat     = !nxt_ins && (rem_d != '0);
      nxt_pair    = nxt_dat && striped && (rem_d > DLEN_W'(1));
      nxt_split   = nxt_dat && striped;
      boundary    = active && (cnt == 2'd3);
      load        = boundary && (nxt_ins || nxt_dat);
      take_stage  = active && (cnt == 2'd2) && nxt_split && !cfg.rd;
      take_direct = boundary && (nxt_ins || (nxt_dat && !cfg.rd && (!striped || nxt_pair)));
      slot_end    = (state == ST_SHIFT) && (cnt == 2'd3);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         cfg        <= '0;
         rem_i      <= '0;
         rem_d      <= '0;
         slot_rx    <= 1'b0;
         slot_hi    <= 1'b0;
         slot_split <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (start) begin
            state <= ST_SETUP;
            cnt   <= '0;
            cfg   <= cfg_in;
            rem_i <= ilen_in;
            rem_d <= dlen_in;
         end
      end else begin
         cnt <= cnt + 2'd1;
         if (boundary) begin
            if (load) begin
               state      <= ST_SHIFT;
               slot_rx    <= nxt_dat && cfg.rd;
               slot_hi    <= nxt_ins || (nxt_dat && (!striped || nxt_pair));
               slot_split <= nxt_split;
               if (nxt_ins) rem_i <= rem_i - ILEN_W'(1);
               else         rem_d <= rem_d - (nxt_pair ? DLEN_W'(2) : DLEN_W'(1));
            end else begin
               state   <= ST_HOLD;
               slot_rx <= 1'b0;
            end
         end
         if ((state == ST_HOLD) && (cnt == 2'd3)) state <= ST_IDLE;
      end
   end
endmodule

// File: rtl/dpq_striper.sv
module dpq_striper
   import dpq_pkg::*;
#(
   parameter int IO_W   = 4,
   parameter int ILEN_W = 3,
   parameter int DLEN_W = 8,
   localparam int BYTE_W = 2 * IO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        sel_in,
   input  logic              stripe_in,
   input  logic              read_in,
   input  logic [ILEN_W-1:0] ilen_in,
   input  logic [DLEN_W-1:0] dlen_in,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_take,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              cs_n,
   output logic              sck,
   output logic [IO_W-1:0]   io_lo_o,
   output logic              io_lo_oe,
   input  logic [IO_W-1:0]   io_lo_i,
   output logic [IO_W-1:0]   io_hi_o,
   output logic              io_hi_oe,
   input  logic [IO_W-1:0]   io_hi_i
);
   if (IO_W < 1)   begin : g_bad_io   $error("IO_W must be at least 1");   end
   if (ILEN_W < 1) begin : g_bad_ilen $error("ILEN_W must be at least 1"); end
   if (DLEN_W < 2) begin : g_bad_dlen $error("DLEN_W must be at least 2"); end

   localparam int LANES = 2;

   dpq_state_e        state;
   logic [1:0]        cnt;
   dpq_cfg_t          cfg, cfg_in;
   logic              slot_rx, slot_hi, slot_split, slot_end;
   logic              load, nxt_split, take_stage, take_direct;
   logic [BYTE_W-1:0] stage_q, pend_q;
   logic              pend_v;
   logic              shifting;

   logic [IO_W-1:0]   lane_i    [LANES];
   logic [IO_W-1:0]   lane_o    [LANES];
   logic [BYTE_W-1:0] lane_rx   [LANES];
   logic [BYTE_W-1:0] lane_load [LANES];

   assign cfg_in = '{sel: sel_in, stripe: stripe_in, rd: read_in};

   dpq_sched #(.ILEN_W(ILEN_W), .DLEN_W(DLEN_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
      .ilen_in(ilen_in), .dlen_in(dlen_in), .state(state), .cnt(cnt),
      .cfg(cfg), .slot_rx(slot_rx), .slot_hi(slot_hi),
      .slot_split(slot_split), .slot_end(slot_end), .load(load),
      .nxt_split(nxt_split), .take_stage(take_stage),
      .take_direct(take_direct)
   );

   assign lane_i[0]    = io_lo_i;
   assign lane_i[1]    = io_hi_i;
   assign lane_load[0] = nxt_split ? stage_q : tx_data;
   assign lane_load[1] = tx_data;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpq_lane #(.IO_W(IO_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .load(load), .load_byte(lane_load[g]),
         .low_half(cnt[1]), .cap_high((state == ST_SHIFT) && (cnt == 2'd1)),
         .io_i(lane_i[g]), .io_o(lane_o[g]), .rx_byte(lane_rx[g])
      );
   end

   assign busy     = (state != ST_IDLE);
   assign cs_n     = !busy;
   assign sck      = (state == ST_SHIFT) && cnt[0];
   assign tx_take  = take_stage || take_direct;
   assign shifting = (state == ST_SHIFT) && !slot_rx;
   assign io_lo_oe = shifting && cfg.sel[0];
   assign io_hi_oe = shifting && cfg.sel[1] && slot_hi;
   assign io_lo_o  = lane_o[0];
   assign io_hi_o  = lane_o[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         pend_q   <= '0;
         pend_v   <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (take_stage) stage_q <= tx_data;
         if (slot_end && slot_rx) begin
            rx_valid <= 1'b1;
            rx_data  <= (!slot_split && (cfg.sel == 2'b10)) ? lane_rx[1] : lane_rx[0];
            pend_v   <= slot_split && slot_hi;
            pend_q   <= lane_rx[1];
         end else if (pend_v) begin
            rx_valid <= 1'b1;
            rx_data  <= pend_q;
            pend_v   <= 1'b0;
         end else begin
            rx_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dpq_check.sv
module dpq_check #(
   parameter int IO_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            sck,
   input logic            io_lo_oe,
   input logic            io_hi_oe,
   input logic [IO_W-1:0] io_lo_o,
   input logic [IO_W-1:0] io_hi_o,
   input logic            rx_valid,
   input logic            tx_take
);
   assert_sck_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sck && !io_lo_oe && !io_hi_oe));

   assert_cs_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> !sck);

   assert_cs_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !$past(sck));

   assert_launch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> ($stable(io_lo_o) && $stable(io_hi_o)));

   assert_rx_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(rx_valid)) |=> !rx_valid);

   assert_rx_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!io_lo_oe && !io_hi_oe));

   assert_take_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> !cs_n);
endmodule

bind dpq_striper dpq_check #(.IO_W(IO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
   .io_lo_oe(io_lo_oe), .io_hi_oe(io_hi_oe), .io_lo_o(io_lo_o),
   .io_hi_o(io_hi_o), .rx_valid(rx_valid), .tx_take(tx_take)
);

// File: tb/sim_dpq_striper.sv
module sim_dpq_striper;
   localparam int IO_W = 4, ILEN_W = 3, DLEN_W = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stripe_in = 1'b0, read_in = 1'b0;
   logic [1:0] sel_in = 2'b00;
   logic [ILEN_W-1:0] ilen_in = '0;
   logic [DLEN_W-1:0] dlen_in = '0;
   logic [7:0] tx_data = '0;
   logic [3:0] io_lo_i = '0, io_hi_i = '0;
   logic tx_take, rx_valid, busy, cs_n, sck, io_lo_oe, io_hi_oe;
   logic [7:0] rx_data;
   logic [3:0] io_lo_o, io_hi_o;

   dpq_striper #(.IO_W(IO_W), .ILEN_W(ILEN_W), .DLEN_W(DLEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in),
      .stripe_in(stripe_in), .read_in(read_in), .ilen_in(ilen_in),
      .dlen_in(dlen_in), .tx_data(tx_data), .tx_take(tx_take),
      .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .cs_n(cs_n),
      .sck(sck), .io_lo_o(io_lo_o), .io_lo_oe(io_lo_oe), .io_lo_i(io_lo_i),
      .io_hi_o(io_hi_o), .io_hi_oe(io_hi_oe), .io_hi_i(io_hi_i)
   );

   always #4 clk = ~clk;

   int tests = 0, fails = 0;
   int lo_n, hi_n, rx_n, busy_cyc, lead, tail, rises, idle_bad = 0, tx_idx;
   int cur_ilen = 0, cur_dlen = 0;
   bit prev_take;
   logic [3:0] lo_cap [0:511];
   logic [3:0] hi_cap [0:511];
   logic [7:0] rx_cap [0:255];
   logic [7:0] ins_b  [0:7];
   logic [7:0] dat_b  [0:127];
   logic [7:0] lm_lo  [0:127];
   logic [7:0] lm_hi  [0:127];
   logic [7:0] exp_b  [0:255];

   function automatic logic [3:0] nib(logic [7:0] b, int k);
      return (k % 2 == 0) ? b[7:4] : b[3:0];
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (prev_take) tx_idx++;
      if (tx_idx < cur_ilen) tx_data = ins_b[tx_idx];
      else if (tx_idx - cur_ilen < 128) tx_data = dat_b[tx_idx - cur_ilen];
      prev_take = tx_take;
      if (cs_n && sck) idle_bad++;
      if (busy) busy_cyc++;
      if (!cs_n) begin
         if (rises == 0 && !sck) lead++;
         if (rises > 0) tail = sck ? 0 : tail + 1;
      end
      if (sck) begin
         int k;
         rises++;
         if (io_lo_oe) begin lo_cap[lo_n] = io_lo_o; lo_n++; end
         if (io_hi_oe) begin hi_cap[hi_n] = io_hi_o; hi_n++; end
         k = rises - 1 - 2 * cur_ilen;
         if (k >= 0 && k < 250) begin
            io_lo_i = nib(lm_lo[k/2], k);
            io_hi_i = nib(lm_hi[k/2], k);
         end
      end
      if (rx_valid && rx_n < 256) begin rx_cap[rx_n] = rx_data; rx_n++; end
   end

   // compares a recorded nibble stream against exp_b[0..n-1]
   task automatic cmp_lane(string tag, int got_n, bit upper, int n);
      int bad = 0;
      for (int i = 0; i < n && 2*i+1 < got_n; i++) begin
         logic [3:0] a0, a1;
         a0 = upper ? hi_cap[2*i] : lo_cap[2*i];
         a1 = upper ? hi_cap[2*i+1] : lo_cap[2*i+1];
         if (a0 !== exp_b[i][7:4] || a1 !== exp_b[i][3:0]) bad++;
      end
      check(got_n == 2*n && bad == 0, tag, got_n - bad, 2*n);
   endtask

   task automatic xfer(int il, int dl, logic [1:0] sel, bit st, bit rd, bit poke, int seed, string tag);
      bit split;
      int slots, n, w;
      split = st && sel == 2'b11;
      @(negedge clk); #1;
      cur_ilen = il; cur_dlen = dl;
      for (int i = 0; i < 8; i++) ins_b[i] = 8'(8'hC0 + i + seed);
      for (int i = 0; i < 128; i++) dat_b[i] = 8'(i * 37 + seed * 11 + 5);
      for (int j = 0; j < 64; j++) begin
         lm_lo[j] = split ? dat_b[2*j] : dat_b[j];
         lm_hi[j] = split ? dat_b[2*j+1] : ~dat_b[j];
      end
      lo_n = 0; hi_n = 0; rx_n = 0; busy_cyc = 0; lead = 0; tail = 0; rises = 0;
      tx_idx = 0; prev_take = 0;
      start = 1; sel_in = sel; stripe_in = st; read_in = rd;
      ilen_in = ILEN_W'(il); dlen_in = DLEN_W'(dl);
      @(negedge clk); #1 start = 0;
      if (poke) begin
         repeat (6) @(negedge clk);
         #1 start = 1; sel_in = 2'b01; stripe_in = 0; read_in = 1; ilen_in = 0; dlen_in = 1;
         @(negedge clk); #1 start = 0;
      end
      w = 0;
      while (busy && w < 4000) begin @(negedge clk); w++; end
      check(w < 4000, "watchdog", w, 0);
      repeat (3) @(negedge clk);
      check(!busy, {tag, " R11 no restart"}, busy, 0);
      slots = il + (split ? (dl + 1) / 2 : dl);
      check(busy_cyc == 8 + 4*slots, {tag, " R2 duration"}, busy_cyc, 8 + 4*slots);
      check(lead >= 2, {tag, " R2 lead"}, lead, 2);
      check(tail >= 2, {tag, " R2 tail"}, tail, 2);
      // lower lane expectation
      n = 0;
      if (sel[0]) begin
         for (int i = 0; i < il; i++) begin exp_b[n] = ins_b[i]; n++; end
         if (!rd) for (int i = 0; i < dl; i++)
            if (!split || i % 2 == 0) begin exp_b[n] = dat_b[i]; n++; end
      end
      cmp_lane({tag, " R3 lower lane"}, lo_n, 1'b0, n);
      n = 0;
      if (sel[1]) begin
         for (int i = 0; i < il; i++) begin exp_b[n] = ins_b[i]; n++; end
         if (!rd) for (int i = 0; i < dl; i++)
            if (!split || i % 2 == 1) begin exp_b[n] = dat_b[i]; n++; end
      end
      cmp_lane({tag, " R7 upper lane"}, hi_n, 1'b1, n);
      if (rd) begin
         int bad = 0;
         for (int i = 0; i < dl && i < rx_n; i++) begin
            logic [7:0] e;
            e = (!split && sel == 2'b10) ? ~dat_b[i] : dat_b[i];
            if (rx_cap[i] !== e) bad++;
         end
         check(rx_n == dl && bad == 0, {tag, " read stream"}, rx_n - bad, dl);
      end else begin
         check(rx_n == 0, {tag, " R12 no read bytes"}, rx_n, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
      check(sck === 1'b0 && busy === 1'b0, "R1 sck busy", int'(sck) + int'(busy), 0);
      check(io_lo_oe === 1'b0 && io_hi_oe === 1'b0, "R1 oe", int'(io_lo_oe) + int'(io_hi_oe), 0);
      check(rx_valid === 1'b0 && tx_take === 1'b0, "R1 strobes", int'(rx_valid) + int'(tx_take), 0);
      #1 rst_n = 1;
      xfer(1, 6, 2'b11, 1, 0, 0, 1, "R4 R8 striped write");
      xfer(1, 5, 2'b11, 1, 0, 0, 2, "R5 odd striped write");
      xfer(2, 3, 2'b11, 0, 0, 0, 3, "R6 mirror write");
      xfer(1, 4, 2'b01, 1, 0, 0, 4, "R7 lower only");
      xfer(1, 3, 2'b10, 0, 0, 0, 5, "R7 upper only");
      xfer(2, 7, 2'b11, 1, 1, 0, 6, "R9 R12 striped read");
      xfer(1, 3, 2'b10, 0, 1, 0, 7, "R10 upper read");
      xfer(1, 3, 2'b01, 0, 1, 0, 8, "R10 lower read");
      xfer(1, 4, 2'b11, 1, 0, 1, 9, "R11 start while busy");
      check(idle_bad == 0, "R13 sck idle", idle_bad, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule